// File: doc/BRIEF.md
# PON Upstream Packet Aligner and Frame Rebuilder

This block sits behind a deserializer on the receive side of a passive optical link. Words of 16 bits arrive, and a fixed-size packet may start on either byte of a word. The block splits each word into two bytes, the upper byte first. It hunts for the sync byte that opens every packet and then stays locked to the packet grid. It reads the sender identifier, the payload length and the end-of-frame flag from each header. It drops the header and any padding, and joins the payloads of consecutive packets from one sender into a single Ethernet frame.

The input is a valid/ready stream. `in_ready` is combinational from registered state only, so it never depends on `in_valid`. A word is taken on a rising clock edge where both `in_valid` and `in_ready` are high. The source must keep `in_word` stable while `in_valid` is high and the word has not yet been taken. The block stops taking input while it sends a frame and during the idle gap that follows. Frames are held in an internal store until the fragment carrying the end-of-frame flag has arrived. A frame that starts is then sent in full, one byte per cycle with no holes, in the style of a GMII transmit interface. The output has no ready, because such a link cannot pause inside a frame.

Top module: `pon_frame_rebuilder`

## Requirements
- R1: Every packet is PKT_BYTES bytes long and starts with a header of HDR_BYTES bytes. Header byte 0 is the sync value SYNC_BYTE (default 0xA5), byte 1 is the 8-bit sender identifier, bytes 2 and 3 hold the payload length (byte 2 is the high byte), and bit 0 of byte 4 is the end-of-frame flag. The remaining header bytes are ignored. Within a word, bits 15:8 are the earlier byte.
- R2: The sync byte is found in either byte lane. After a packet is found, the next packet is expected in the byte directly after it, so the lane choice is kept from one packet to the next.
- R3: Only the first `length` payload bytes of a packet are forwarded. The padding bytes that follow them, up to the end of the packet, never reach the output.
- R4: A length field greater than PAY_MAX marks the packet as errored. The partial frame is discarded, and so are the fragments that follow it, up to and including the next fragment that carries the end-of-frame flag.
- R5: If a fragment arrives with an identifier different from the frame in progress, that frame is aborted and the new fragment starts a fresh frame.
- R6: If the byte where the next sync is expected is not the sync value, lock is lost and the block hunts byte by byte. A frame in progress is discarded along with its fragments up to its end-of-frame fragment.
- R7: Payloads of consecutive fragments are joined in arrival order. The frame is sent once a fragment with the end-of-frame flag ends. A frame with no bytes produces no output.
- R8: `out_valid` stays high for every byte of a frame with no gaps, and `out_id` holds the frame's sender identifier for the whole frame.
- R9: Between two frames, `out_valid` is low for at least GAP_CYCLES cycles.
- R10: Words are taken only on cycles with `in_valid` and `in_ready` both high. A source that pauses loses no data.
- R11: After reset, `out_valid` is low and `in_ready` is high.
- R12: A frame that would grow beyond FRAME_MAX bytes is discarded, up to and including its end-of-frame fragment. A frame of exactly FRAME_MAX bytes is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block can take a word this cycle |
| in_word | input | 16 | Deserialized word; bits 15:8 are the earlier byte |
| out_valid | output | 1 | Frame byte is valid; high for the whole frame |
| out_data | output | 8 | Frame byte |
| out_id | output | 8 | Sender identifier of the frame being sent |

## Verification
The bench uses a small packet size. For every legal payload length, it sends single-fragment frames starting in both byte lanes. A block that skipped padding wrongly or lost the lane would corrupt bytes or lengths. Multi-fragment frames are sent with the source pausing now and then. This catches words taken twice or dropped under back-pressure, and fragments joined in the wrong order. The bench also injects an over-long length, a change of identifier in mid-frame, a broken sync and a frame of exactly and just over the storage limit. A block that got these wrong would emit stale partial frames, emit a frame's tail as a frame of its own, or drop the frame that follows.

// File: rtl/pon_rx_pkg.sv
`timescale 1ns/1ps
package pon_rx_pkg;
  localparam int LEN_W = 16;

  typedef enum logic [1:0] {
    PS_HUNT   = 2'd0,
    PS_EXPECT = 2'd1,
    PS_BODY   = 2'd2
  } parse_st_t;

  // One byte's worth of parser events.
  typedef struct packed {
    logic       start;    // last header byte consumed
    logic       bad_len;  // length field above limit
    logic [7:0] id;       // sender identifier of packet
    logic       pay;      // data is a payload byte to keep
    logic [7:0] data;     // the byte itself
    logic       fin;      // last byte of packet consumed
    logic       last;     // packet carries end-of-frame
    logic       lost;     // expected sync missing
  } frag_ev_t;
endpackage

// File: rtl/pon_word_splitter.sv
`timescale 1ns/1ps
module pon_word_splitter (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_word,
  output logic        byte_valid,
  output logic [7:0]  byte_data,
  input  logic        byte_ready
);
  logic [15:0] hold;
  logic [1:0]  left;
  logic        take;

  assign take       = byte_valid & byte_ready;
  assign byte_valid = (left != 2'd0);
  assign byte_data  = (left == 2'd2) ? hold[15:8] : hold[7:0];
  assign in_ready   = (left == 2'd0) | ((left == 2'd1) & take);

  always_ff @(posedge clk) begin
    if (rst) begin
      left <= 2'd0;
    end else if (in_valid && in_ready) begin
      left <= 2'd2;
    end else if (take) begin
      left <= left - 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) hold <= in_word;
  end
endmodule

// File: rtl/pon_pkt_parser.sv
`timescale 1ns/1ps
module pon_pkt_parser
  import pon_rx_pkg::*;
#(
  parameter int         PKT_BYTES = 280,
  parameter int         HDR_BYTES = 12,
  parameter int         PAY_MAX   = 268,
  parameter logic [7:0] SYNC_BYTE = 8'hA5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_valid,
  input  logic [7:0] byte_data,
  input  logic       sink_ready,
  output frag_ev_t   ev
);
  localparam int POS_W = $clog2(PKT_BYTES);
  localparam logic [POS_W-1:0] POS_HDR_LAST = POS_W'(HDR_BYTES - 1);
  localparam logic [POS_W-1:0] POS_LAST     = POS_W'(PKT_BYTES - 1);
  localparam logic [POS_W-1:0] POS_ID       = POS_W'(1);
  localparam logic [POS_W-1:0] POS_LEN_HI   = POS_W'(2);
  localparam logic [POS_W-1:0] POS_LEN_LO   = POS_W'(3);
  localparam logic [POS_W-1:0] POS_FLAGS    = POS_W'(4);
  localparam logic [LEN_W-1:0] LEN_HDR      = LEN_W'(HDR_BYTES);
  localparam logic [LEN_W-1:0] LEN_LIMIT    = LEN_W'(PAY_MAX);

  parse_st_t        st;
  logic [POS_W-1:0] pos;
  logic [7:0]       id_r;
  logic [LEN_W-1:0] len_r;
  logic             last_r;
  logic             take;
  logic             is_sync;
  logic [LEN_W-1:0] pos_ext;
  logic [LEN_W-1:0] pay_off;

  assign take    = byte_valid & sink_ready;
  assign is_sync = (byte_data == SYNC_BYTE);
  assign pos_ext = LEN_W'(pos);
  assign pay_off = pos_ext - LEN_HDR;

  always_comb begin
    ev         = '0;
    ev.id      = id_r;
    ev.data    = byte_data;
    ev.last    = last_r;
    ev.bad_len = (len_r > LEN_LIMIT);
    if (take) begin
      case (st)
        PS_EXPECT: ev.lost = !is_sync;
        PS_BODY: begin
          ev.start = (pos == POS_HDR_LAST);
          ev.pay   = (pos_ext >= LEN_HDR) && (pay_off < len_r);
          ev.fin   = (pos == POS_LAST);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= PS_HUNT;
      pos    <= '0;
      id_r   <= '0;
      len_r  <= '0;
      last_r <= 1'b0;
    end else if (take) begin
      case (st)
        PS_HUNT, PS_EXPECT: begin
          if (is_sync) begin
            st  <= PS_BODY;
            pos <= POS_ID;
          end else begin
            st  <= PS_HUNT;
          end
        end
        PS_BODY: begin
          if (pos == POS_ID)     id_r          <= byte_data;
          if (pos == POS_LEN_HI) len_r[15:8]   <= byte_data;
          if (pos == POS_LEN_LO) len_r[7:0]    <= byte_data;
          if (pos == POS_FLAGS)  last_r        <= byte_data[0];
          if (pos == POS_LAST) begin
            st  <= PS_EXPECT;
            pos <= '0;
          end else begin
            pos <= pos + 1'b1;
          end
        end
        default: st <= PS_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/pon_frame_store.sv
`timescale 1ns/1ps
module pon_frame_store
  import pon_rx_pkg::*;
#(
  parameter int FRAME_MAX  = 2048,
  parameter int GAP_CYCLES = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  frag_ev_t   ev,
  output logic       sink_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic [7:0] out_id
);
  localparam int CNT_W = $clog2(FRAME_MAX + 1);
  localparam int ADR_W = $clog2(FRAME_MAX);
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_MAX);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(GAP_CYCLES);

  logic [7:0]       mem [FRAME_MAX];
  logic [CNT_W-1:0] wr_cnt, n_wr;
  logic [CNT_W-1:0] rd_ptr, n_rd;
  logic             in_frame, n_in;
  logic             skip, n_skip;
  logic [7:0]       fid, n_fid;
  logic             sending, n_send;
  logic [GAP_W-1:0] gap_cnt, n_gap;
  logic             we;

  assign sink_ready = !(sending || (gap_cnt != '0));
  assign out_valid  = sending;
  assign out_data   = mem[rd_ptr[ADR_W-1:0]];
  assign out_id     = fid;

  always_comb begin
    n_wr   = wr_cnt;
    n_rd   = rd_ptr;
    n_in   = in_frame;
    n_skip = skip;
    n_fid  = fid;
    n_send = sending;
    n_gap  = gap_cnt;
    we     = 1'b0;

    // drain side
    if (sending) begin
      if (rd_ptr == wr_cnt - 1'b1) begin
        n_send = 1'b0;
        n_gap  = GAP_LOAD;
        n_wr   = '0;
        n_rd   = '0;
      end else begin
        n_rd = rd_ptr + 1'b1;
      end
    end else if (gap_cnt != '0) begin
      n_gap = gap_cnt - 1'b1;
    end

    // fill side: events only arrive while not busy
    if (ev.lost && in_frame) begin
      n_in   = 1'b0;
      n_wr   = '0;
      n_skip = 1'b1;
    end

    if (ev.start && !skip) begin
      if (ev.bad_len) begin
        n_in   = 1'b0;
        n_wr   = '0;
        n_skip = 1'b1;
      end else if (in_frame && (ev.id != fid)) begin
        n_wr  = '0;
        n_fid = ev.id;
      end else begin
        n_in  = 1'b1;
        n_fid = ev.id;
      end
    end

    if (ev.pay && in_frame && !skip) begin
      if (wr_cnt == CNT_FULL) begin
        n_in   = 1'b0;
        n_wr   = '0;
        n_skip = 1'b1;
      end else begin
        we   = 1'b1;
        n_wr = wr_cnt + 1'b1;
      end
    end

    if (ev.fin && ev.last) begin
      if (n_skip) begin
        n_skip = 1'b0;
      end else if (n_in && (n_wr != '0)) begin
        n_send = 1'b1;
        n_rd   = '0;
        n_in   = 1'b0;
      end else begin
        n_in = 1'b0;
        n_wr = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_cnt   <= '0;
      rd_ptr   <= '0;
      in_frame <= 1'b0;
      skip     <= 1'b0;
      fid      <= '0;
      sending  <= 1'b0;
      gap_cnt  <= '0;
    end else begin
      wr_cnt   <= n_wr;
      rd_ptr   <= n_rd;
      in_frame <= n_in;
      skip     <= n_skip;
      fid      <= n_fid;
      sending  <= n_send;
      gap_cnt  <= n_gap;
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[wr_cnt[ADR_W-1:0]] <= ev.data;
  end
endmodule

// File: rtl/pon_frame_rebuilder.sv
`timescale 1ns/1ps
module pon_frame_rebuilder
  import pon_rx_pkg::*;
#(
  parameter int         PKT_BYTES  = 280,
  parameter int         HDR_BYTES  = 12,
  parameter int         PAY_MAX    = 268,
  parameter int         FRAME_MAX  = 2048,
  parameter int         GAP_CYCLES = 12,
  parameter logic [7:0] SYNC_BYTE  = 8'hA5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_word,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic [7:0]  out_id
);
  logic       byte_valid;
  logic [7:0] byte_data;
  logic       sink_ready;
  frag_ev_t   ev;

  pon_word_splitter split_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_word    (in_word),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .byte_ready (sink_ready)
  );

  pon_pkt_parser #(
    .PKT_BYTES (PKT_BYTES),
    .HDR_BYTES (HDR_BYTES),
    .PAY_MAX   (PAY_MAX),
    .SYNC_BYTE (SYNC_BYTE)
  ) parse_i (
    .clk        (clk),
    .rst        (rst),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .sink_ready (sink_ready),
    .ev         (ev)
  );

  pon_frame_store #(
    .FRAME_MAX  (FRAME_MAX),
    .GAP_CYCLES (GAP_CYCLES)
  ) store_i (
    .clk        (clk),
    .rst        (rst),
    .ev         (ev),
    .sink_ready (sink_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_id     (out_id)
  );
endmodule

// File: rtl/pon_frame_rebuilder_chk.sv
`timescale 1ns/1ps
module pon_frame_rebuilder_chk #(
  parameter int FRAME_MAX  = 2048,
  parameter int GAP_CYCLES = 12
) (
  input logic       clk,
  input logic       rst,
  input logic       in_ready,
  input logic       out_valid,
  input logic [7:0] out_id
);
  localparam int IDLE_W = $clog2(GAP_CYCLES + 1);
  localparam int RUN_W  = $clog2(FRAME_MAX + 1);

  logic [IDLE_W-1:0] idle;
  logic [RUN_W-1:0]  run;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle <= IDLE_W'(GAP_CYCLES);
      run  <= '0;
    end else begin
      if (out_valid) idle <= '0;
      else if (idle != IDLE_W'(GAP_CYCLES)) idle <= idle + 1'b1;
      if (!out_valid) run <= '0;
      else if (run != RUN_W'(FRAME_MAX)) run <= run + 1'b1;
    end
  end

  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (idle >= IDLE_W'(GAP_CYCLES))); // R9

  AST_ID_HELD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid)) |-> $stable(out_id)); // R8

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (run < RUN_W'(FRAME_MAX))); // R12

  AST_RESET_EXIT: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && in_ready)); // R11
endmodule

bind pon_frame_rebuilder pon_frame_rebuilder_chk #(
  .FRAME_MAX  (FRAME_MAX),
  .GAP_CYCLES (GAP_CYCLES)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_id    (out_id)
);

// File: tb/pon_frame_rebuilder_tb_top.sv
`timescale 1ns/1ps
module pon_frame_rebuilder_tb_top;
  localparam int PKT   = 20;
  localparam int HDR   = 12;
  localparam int PMAX  = 8;
  localparam int FMAX  = 32;
  localparam int GAP   = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = 16'h0;
  logic        out_valid;
  logic [7:0]  out_data;
  logic [7:0]  out_id;

  always #2 clk = ~clk;

  pon_frame_rebuilder #(
    .PKT_BYTES (PKT), .HDR_BYTES (HDR), .PAY_MAX (PMAX),
    .FRAME_MAX (FMAX), .GAP_CYCLES (GAP), .SYNC_BYTE (8'hA5)
  ) dut_i (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_ready (in_ready),
    .in_word (in_word), .out_valid (out_valid), .out_data (out_data), .out_id (out_id)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] tx_q[$];
  logic [7:0] exp_data[$];
  int         exp_len[$];
  logic [7:0] exp_id[$];

  // reference frame model, built from the requirements
  logic [7:0] m_cur[$];
  bit         m_in = 1'b0;
  bit         m_skip = 1'b0;
  logic [7:0] m_id = 8'h0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic m_start(input logic [7:0] id, input bit bad);
    if (m_skip) return;
    if (bad) begin
      m_in = 1'b0; m_cur.delete(); m_skip = 1'b1;
    end else if (m_in && id != m_id) begin
      m_cur.delete(); m_id = id;
    end else begin
      m_in = 1'b1; m_id = id;
    end
  endtask

  task automatic m_pay(input logic [7:0] b);
    if (m_in && !m_skip) begin
      if (m_cur.size() == FMAX) begin
        m_in = 1'b0; m_cur.delete(); m_skip = 1'b1;
      end else begin
        m_cur.push_back(b);
      end
    end
  endtask

  task automatic m_end(input bit eof);
    if (!eof) return;
    if (m_skip) begin
      m_skip = 1'b0;
    end else if (m_in && m_cur.size() != 0) begin
      exp_len.push_back(m_cur.size());
      exp_id.push_back(m_id);
      foreach (m_cur[i]) exp_data.push_back(m_cur[i]);
      m_cur.delete(); m_in = 1'b0;
    end else begin
      m_cur.delete(); m_in = 1'b0;
    end
  endtask

  task automatic m_lost();
    if (m_in) begin
      m_in = 1'b0; m_cur.delete(); m_skip = 1'b1;
    end
  endtask

  // R1 layout: sync, id, len hi, len lo, flags bit0 = end-of-frame
  task automatic add_pkt(input logic [7:0] id, input int len, input bit eof, input int seed);
    logic [7:0] d;
    tx_q.push_back(8'hA5);
    tx_q.push_back(id);
    tx_q.push_back(8'(len >> 8));
    tx_q.push_back(8'(len));
    tx_q.push_back({7'b0, eof});
    for (int i = 5; i < HDR; i++) tx_q.push_back(8'h00);
    m_start(id, len > PMAX);
    for (int i = 0; i < PKT - HDR; i++) begin
      if (i < len) begin
        d = 8'(((seed * 13) + (i * 3) + 1) & 8'h7F);
        tx_q.push_back(d);
        m_pay(d);
      end else begin
        tx_q.push_back(8'hEE);
      end
    end
    m_end(eof);
  endtask

  task automatic add_junk();
    tx_q.push_back(8'h00);
    m_lost();
  endtask

  task automatic drive_stream(input bit stall, input string tag);
    int  k;
    int  cyc;
    bit  acc;
    bit  prev_acc;
    k = 0; cyc = 0; prev_acc = 1'b1;
    if ((tx_q.size() % 2) != 0) tx_q.push_back(8'h00);
    while (k < tx_q.size()) begin
      @(negedge clk);
      cyc++;
      if (stall && prev_acc && (cyc % 3 == 0)) begin
        in_valid = 1'b0;
      end else begin
        in_valid = 1'b1;
        in_word  = {tx_q[k], tx_q[k+1]};
      end
      #1;
      acc = in_valid && in_ready;
      prev_acc = acc;
      @(posedge clk);
      if (acc) k += 2;
    end
    @(negedge clk);
    in_valid = 1'b0;
    tx_q.delete();
    repeat (150) @(negedge clk);
    chk(exp_len.size() == 0, tag, exp_len.size(), 0);
  endtask

  // output monitor
  logic [7:0] got[$];
  logic [7:0] got_id;
  bit         run_on = 1'b0;
  bit         first_frame = 1'b1;
  bit         id_bad = 1'b0;
  int         idle = 0;

  task automatic finish_frame();
    int         n;
    logic [7:0] eid;
    bit         ok;
    if (exp_len.size() == 0) begin
      chk(1'b0, "R7 unexpected frame", got.size(), 0);
      return;
    end
    n   = exp_len.pop_front();
    eid = exp_id.pop_front();
    ok  = (got.size() == n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      e = exp_data.pop_front();
      if (i < got.size() && got[i] !== e) ok = 1'b0;
    end
    chk(ok, "R3 R7 frame bytes/length", got.size(), n);
    chk((got_id == eid) && !id_bad, "R8 frame id held", int'(got_id), int'(eid));
  endtask

  always @(negedge clk) begin
    if (rst) begin
      run_on = 1'b0;
      idle   = GAP;
    end else if (out_valid) begin
      if (!run_on) begin
        run_on = 1'b1;
        got.delete();
        got_id = out_id;
        id_bad = 1'b0;
        if (!first_frame) chk(idle >= GAP, "R9 idle gap", idle, GAP);
        first_frame = 1'b0;
      end
      got.push_back(out_data);
      if (out_id !== got_id) id_bad = 1'b1;
      idle = 0;
    end else begin
      if (run_on) begin
        run_on = 1'b0;
        finish_frame();
      end
      idle++;
    end
  end

  int cyc_total = 0;
  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc_total, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R11 in_ready after reset", int'(in_ready), 1);

    // R1 R2 R3: every length, both byte lanes
    for (int lane = 1; lane <= 2; lane++) begin
      for (int j = 0; j < lane; j++) add_junk();
      for (int len = 0; len <= PMAX; len++)
        add_pkt(8'(len + 1 + lane * 16), len, 1'b1, len + lane);
      drive_stream(lane == 2, "R2 lane sweep complete");
    end

    // R7 R10: multi-fragment frames with source pauses
    add_junk();
    add_pkt(8'h21, 8, 1'b0, 3); add_pkt(8'h21, 8, 1'b0, 4); add_pkt(8'h21, 3, 1'b1, 5);
    add_pkt(8'h22, 5, 1'b0, 6); add_pkt(8'h22, 0, 1'b0, 7); add_pkt(8'h22, 8, 1'b1, 8);
    add_pkt(8'h23, 1, 1'b0, 9); add_pkt(8'h23, 1, 1'b0, 10); add_pkt(8'h23, 1, 1'b0, 11);
    add_pkt(8'h23, 1, 1'b1, 12);
    drive_stream(1'b1, "R10 paused source");

    // R4: over-long length field
    add_junk();
    add_pkt(8'h07, 8, 1'b0, 13); add_pkt(8'h07, PMAX + 1, 1'b0, 14); add_pkt(8'h07, 4, 1'b1, 15);
    add_pkt(8'h08, 6, 1'b1, 16);
    add_pkt(8'h09, PMAX + 1, 1'b1, 17); add_pkt(8'h09, 3, 1'b1, 18);
    drive_stream(1'b0, "R4 errored length");

    // R5: identifier changes mid-frame
    add_junk();
    add_pkt(8'h03, 8, 1'b0, 19); add_pkt(8'h04, 5, 1'b0, 20); add_pkt(8'h04, 2, 1'b1, 21);
    drive_stream(1'b0, "R5 id change");

    // R6: broken sync mid-frame
    add_junk();
    add_pkt(8'h05, 8, 1'b0, 22);
    add_junk();
    add_pkt(8'h05, 3, 1'b1, 23);
    add_pkt(8'h06, 4, 1'b1, 24);
    drive_stream(1'b1, "R6 sync loss");

    // R12: just over and exactly at the storage limit
    add_junk();
    for (int f = 0; f < 4; f++) add_pkt(8'h02, 8, 1'b0, 25 + f);
    add_pkt(8'h02, 1, 1'b1, 30);
    for (int f = 0; f < 4; f++) add_pkt(8'h0C, 8, 1'b0, 31 + f);
    add_pkt(8'h0C, 0, 1'b1, 36);
    drive_stream(1'b0, "R12 storage limit");

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule